// File: doc/BRIEF.md
# DDR2 Column Read Issuer

This block sits between a request source and the DDR2 command bus. Each request names a bank, a starting column, whether the row should be closed automatically at the end of the burst, and whether it is a read or a write. The block turns each accepted request into a column command on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. A request is presented on the request inputs and held there until the block takes it. Row opening is done elsewhere; an activation notice input tells the block which bank has just had a row opened.

The block enforces the spacing rules that apply to reads. It can issue a column command early after an activation by relying on additive latency. It spaces reads at the column-to-column minimum, and it lets an 8-beat read be cut short at its 4-beat point by a following read. It keeps a write back until the data of every earlier read has left the bus. It also tracks which banks have an open row, and it refuses column requests to a bank whose row was closed by an automatic precharge.

Top module: `ddr2_read_issuer`

## Requirements
- R1: After reset the command pins drive NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), req_reject is low, and every bank counts as closed.
- R2: An accepted read request appears on the pins on the clock after acceptance as cs_n=0, ras_n=1, cas_n=0, we_n=1, with the bank on ba and the start column on addr[9:0]. Every cycle with no command drives NOP.
- R3: An accepted write request appears one clock after acceptance as cs_n=0, ras_n=1, cas_n=0, we_n=0. A read may follow a write BL/2 clocks after it.
- R4: addr[10] carries the request's auto-precharge choice (1 = close the row after the burst). All address bits above bit 10 are driven to 0.
- R5: Two reads are at least BL/2 clocks apart. When the earlier read has auto-precharge off, the gap may shrink to 2 clocks, which is the 4-beat boundary. With BL=8 this gives 2 clocks after a read without auto-precharge and 4 clocks after one with it.
- R6: A write is issued no sooner than BL/2+3 clocks after the most recent read. This equals RL+BL/2+2-WL with WL=RL-1.
- R7: After an activation notice for a bank, no column command to that bank reaches the pins earlier than max(TRCD-AL,1) clocks after that notice edge.
- R8: A request to a closed bank is refused. req_ready and req_reject are high, no command is issued, and the pins stay NOP. A column command with addr[10]=1 closes its bank until a new activation notice for that bank arrives.
- R9: While a spacing rule is unmet, req_ready is low and the request is held. The command is issued on the first clock the rule allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | A row was just opened in act_bank |
| act_bank | input | BANK_W | Bank of the activation notice |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | 10 | Starting column |
| req_ap | input | 1 | Auto-precharge wanted |
| req_ready | output | 1 | Request can be taken this clock (issued or refused) |
| req_reject | output | 1 | Request taken this clock is refused (closed bank) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |

## Verification
Two situations are hard to reach. The first is a short 2-clock read gap that must be followed at once by a long read-to-write hold. The second is a bank closed by its own auto-precharge command that must be re-opened later. The stimulus chains requests back to back, so that every rule is the one limiting the next issue. It runs reads without auto-precharge, then a read with it, a write, and a request to the just-closed bank. Each command's clock distance from the previous one is compared with the gap the rules predict. A re-activation notice then brings the closed bank back, and the stimulus checks that requests to it are accepted again.

// File: rtl/ddr2rd_pkg.sv
package ddr2rd_pkg;

    // command pin order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100
    } cmd_e;

    localparam int COL_W = 10;

    typedef struct packed {
        logic             wr;
        logic [2:0]       bank;
        logic [COL_W-1:0] col;
        logic             ap;
    } colreq_t;

    function automatic int unsigned at_least_one(input int value);
        return (value < 1) ? 1 : value;
    endfunction

endpackage

// File: rtl/ddr2rd_bank_tracker.sv
module ddr2rd_bank_tracker #(
    parameter int NUM_BANKS = 8,
    parameter int EARLY     = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CW       = $clog2(EARLY + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 act_valid,
    input  logic [BANK_W-1:0]    act_bank,
    input  logic                 iss_valid,
    input  logic [BANK_W-1:0]    iss_bank,
    input  logic                 iss_ap,
    output logic [NUM_BANKS-1:0] open_mask,
    output logic [NUM_BANKS-1:0] rcd_ok
);
    localparam logic [CW-1:0] LOAD = CW'(EARLY - 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic          open_q;
        logic [CW-1:0] wait_q;
        logic          act_hit, close_hit;

        assign act_hit   = act_valid && (act_bank == BANK_W'(b));
        assign close_hit = iss_valid && iss_ap && (iss_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                wait_q <= '0;
            end else if (act_hit) begin
                open_q <= 1'b1;
                wait_q <= LOAD;
            end else begin
                if (close_hit) open_q <= 1'b0;
                if (wait_q != '0) wait_q <= wait_q - 1'b1;
            end
        end

        assign open_mask[b] = open_q;
        assign rcd_ok[b]    = (wait_q == '0);
    end

endmodule

// File: rtl/ddr2rd_spacing_timer.sv
module ddr2rd_spacing_timer #(
    parameter int BL = 8,
    localparam int HALF  = BL / 2,
    localparam int SHORT = 2,
    localparam int RTW   = HALF + 3,
    localparam int CW    = $clog2(RTW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic iss_valid,
    input  logic iss_wr,
    input  logic iss_ap,
    output logic rd_ok,
    output logic wr_ok
);
    localparam logic [CW-1:0] HALF_M1  = CW'(HALF - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT - 1);
    localparam logic [CW-1:0] RTW_M1   = CW'(RTW - 1);

    logic [CW-1:0] ccd_q;
    logic [CW-1:0] rtw_q;
    logic [CW-1:0] ccd_load;

    // a read left open may be cut at its 4-beat point by the next read
    always_comb begin
        if (iss_wr || iss_ap) ccd_load = HALF_M1;
        else                  ccd_load = SHORT_M1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccd_q <= '0;
            rtw_q <= '0;
        end else begin
            if (iss_valid)          ccd_q <= ccd_load;
            else if (ccd_q != '0)   ccd_q <= ccd_q - 1'b1;

            if (iss_valid && !iss_wr) rtw_q <= RTW_M1;
            else if (rtw_q != '0)     rtw_q <= rtw_q - 1'b1;
        end
    end

    assign rd_ok = (ccd_q == '0);
    assign wr_ok = (ccd_q == '0) && (rtw_q == '0);

endmodule

// File: rtl/ddr2rd_cmd_encoder.sv
module ddr2rd_cmd_encoder
    import ddr2rd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  colreq_t           req,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    cmd_e              cmd_q;
    logic [BANK_W-1:0] ba_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else if (issue) begin
            cmd_q  <= req.wr ? CMD_WR : CMD_RD;
            ba_q   <= BANK_W'(req.bank);
            addr_q <= {{(ADDR_W-COL_W-1){1'b0}}, req.ap, req.col};
        end else begin
            cmd_q  <= CMD_NOP;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign ba   = ba_q;
    assign addr = addr_q;

endmodule

// File: rtl/ddr2_read_issuer.sv
module ddr2_read_issuer
    import ddr2rd_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 14,
    parameter int BL        = 8,
    parameter int AL        = 3,
    parameter int TRCD      = 5,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int EARLY    = at_least_one(TRCD - AL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic              req_ready,
    output logic              req_reject,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    logic [NUM_BANKS-1:0] open_mask;
    logic [NUM_BANKS-1:0] rcd_ok;
    logic                 rd_ok, wr_ok;
    logic                 bank_open, time_ok, issue;
    colreq_t              req;

    assign bank_open  = open_mask[req_bank];
    assign time_ok    = rcd_ok[req_bank] && (req_write ? wr_ok : rd_ok);
    assign req_ready  = !bank_open || time_ok;
    assign req_reject = req_valid && !bank_open;
    assign issue      = req_valid && bank_open && time_ok;

    always_comb begin
        req      = '0;
        req.wr   = req_write;
        req.bank = 3'(req_bank);
        req.col  = req_col;
        req.ap   = req_ap;
    end

    ddr2rd_bank_tracker #(.NUM_BANKS(NUM_BANKS), .EARLY(EARLY)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .act_valid (act_valid),
        .act_bank  (act_bank),
        .iss_valid (issue),
        .iss_bank  (req_bank),
        .iss_ap    (req_ap),
        .open_mask (open_mask),
        .rcd_ok    (rcd_ok)
    );

    ddr2rd_spacing_timer #(.BL(BL)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (issue),
        .iss_wr    (req_write),
        .iss_ap    (req_ap),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok)
    );

    ddr2rd_cmd_encoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_enc (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .req   (req),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

endmodule

// File: rtl/ddr2_read_issuer_chk.sv
module ddr2_read_issuer_chk #(
    parameter int BL     = 8,
    parameter int ADDR_W = 14,
    localparam int RTW   = BL / 2 + 3,
    localparam int SW    = $clog2(RTW + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ap,
    input logic              req_ready,
    input logic              req_reject,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr
);
    logic col_cmd, rd_cmd, wr_cmd, taken;
    logic [SW-1:0] since_rd;

    assign col_cmd = !cs_n && ras_n && !cas_n;
    assign rd_cmd  = col_cmd && we_n;
    assign wr_cmd  = col_cmd && !we_n;
    assign taken   = req_valid && req_ready && !req_reject;

    always_ff @(posedge clk) begin
        if (rst)                          since_rd <= '0;
        else if (rd_cmd)                  since_rd <= SW'(1);
        else if (since_rd != '0 && since_rd != {SW{1'b1}}) since_rd <= since_rd + 1'b1;
    end

    // R2
    enc_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> (!cs_n && ras_n));

    // R2
    rd_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && !req_write) |=> (rd_cmd));

    // R3
    wr_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && req_write) |=> (wr_cmd));

    // R4
    a10_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> (addr[10] == $past(req_ap)));

    // R5
    rd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |-> !$past(col_cmd));

    // R6
    rd_to_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |-> (since_rd == '0 || since_rd >= SW'(RTW)));

    // R8
    reject_nop_chk: assert property (@(posedge clk) disable iff (rst)
        req_reject |=> cas_n);

endmodule

bind ddr2_read_issuer ddr2_read_issuer_chk #(.BL(BL), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ap     (req_ap),
    .req_ready  (req_ready),
    .req_reject (req_reject),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr)
);

// File: tb/tb_ddr2_read_issuer.sv
module tb_ddr2_read_issuer;
    localparam int BANK_W = 3;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              act_valid = 1'b0;
    logic [BANK_W-1:0] act_bank = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [9:0]        req_col = '0;
    logic              req_ap = 1'b0;
    logic              req_ready, req_reject;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [BANK_W-1:0] ba;
    logic [ADDR_W-1:0] addr;

    ddr2_read_issuer dut (
        .clk(clk), .rst(rst), .act_valid(act_valid), .act_bank(act_bank),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_col(req_col), .req_ap(req_ap), .req_ready(req_ready),
        .req_reject(req_reject), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit wr;
        int bank;
        int col;
        bit ap;
        int gap;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int last_cmd = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per column command on the pins
    always @(negedge clk) begin
        if (!rst && !cas_n) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected command", int'(ba), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cs_n == 1'b0 && ras_n == 1'b1, {e.tag, " R2 encoding"}, int'({cs_n, ras_n}), 2);
                chk(!we_n == e.wr, {e.tag, " R2/R3 write flag"}, int'(!we_n), int'(e.wr));
                chk(int'(ba) == e.bank, {e.tag, " R2 bank"}, int'(ba), e.bank);
                chk(int'(addr[9:0]) == e.col, {e.tag, " R2 column"}, int'(addr[9:0]), e.col);
                chk(addr[10] == e.ap, {e.tag, " R4 auto-precharge bit"}, int'(addr[10]), int'(e.ap));
                chk(addr[13:11] == 3'b000, {e.tag, " R4 upper address"}, int'(addr[13:11]), 0);
                if (e.gap >= 0)
                    chk(cyc - last_cmd == e.gap, {e.tag, " R9 gap"}, cyc - last_cmd, e.gap);
            end
            last_cmd = cyc;
        end
    end

    task automatic activate(input int bank);
        @(negedge clk);
        act_valid = 1'b1;
        act_bank  = BANK_W'(bank);
        @(posedge clk);
        #1 act_valid = 1'b0;
    endtask

    task automatic send(input bit wr, input int bank, input int col, input bit ap,
                        input bit rej, input int gap, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_bank  = BANK_W'(bank);
        req_col   = 10'(col);
        req_ap    = ap;
        #1;
        if (rej) begin
            chk(req_reject && req_ready, {tag, " R8 refused"}, int'({req_reject, req_ready}), 3);
            @(posedge clk);
            #1 req_valid = 1'b0;
            @(negedge clk);
            chk(cas_n && ras_n && we_n && !cs_n, {tag, " R8 pins NOP"}, int'({cs_n, ras_n, cas_n, we_n}), 7);
            return;
        end
        e.wr = wr; e.bank = bank; e.col = col; e.ap = ap; e.gap = gap; e.tag = tag;
        q.push_back(e);
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        chk(!req_reject, {tag, " R8 not refused"}, int'(req_reject), 0);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(!req_reject, "R1 no reject when idle", int'(req_reject), 0);

        // R1/R8 bank closed after reset
        send(1'b0, 0, 16, 1'b0, 1'b1, -1, "R1 closed-at-reset");

        activate(1);
        activate(0);
        // R7 early issue gate: EARLY = TRCD-AL = 2
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bank = 3'd0; req_col = 10'h010; req_ap = 1'b0;
        #1 chk(!req_ready, "R7 held one clock after activation", int'(req_ready), 0);
        @(negedge clk);
        #1 chk(req_ready, "R7 ready two clocks after activation", int'(req_ready), 1);
        begin
            exp_t e;
            e.wr = 1'b0; e.bank = 0; e.col = 16; e.ap = 1'b0; e.gap = -1; e.tag = "R7 first read";
            q.push_back(e);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;

        send(1'b0, 1, 32,    1'b0, 1'b0, 2, "R5 short gap after open read");
        send(1'b0, 1, 48,    1'b1, 1'b0, 2, "R5 short gap again");
        send(1'b0, 0, 64,    1'b0, 1'b0, 4, "R5 full gap after precharge read");
        send(1'b1, 0, 80,    1'b0, 1'b0, 7, "R6 read to write");
        send(1'b0, 0, 96,    1'b0, 1'b0, 4, "R3 write to read");
        send(1'b0, 1, 112,   1'b0, 1'b1, -1, "R8 bank closed by read");
        activate(1);
        send(1'b0, 1, 112,   1'b0, 1'b0, -1, "R8 reopened bank");
        send(1'b1, 1, 8,     1'b1, 1'b0, 7, "R6 write with precharge");
        send(1'b0, 1, 9,     1'b0, 1'b1, -1, "R8 bank closed by write");
        send(1'b0, 0, 1023,  1'b1, 1'b0, -1, "R4 top column with precharge");

        repeat (12) @(negedge clk);
        chk(q.size() == 0, "R9 all expected commands issued", q.size(), 0);
        finish_run();
    end

endmodule